// File: doc/BRIEF.md
# No-Fill Miss Tracking Table

This block tracks outstanding data-cache misses. Each tracked miss carries a suppress-install flag. A requester sets the flag when the load that missed is not yet known to be safe, for example a load still under speculation. When memory answers, the data always goes back to the requester. The line is written into the cache array only if the flag has been cleared by then.

A later authorization event names the request ID of an outstanding miss. If it arrives before the data, it turns that miss into an ordinary install, which keeps the set of suppressed lines small. If it arrives after a suppressed response has already completed, no install happens. The table raises a safe-address pulse carrying the line address instead, so that logic outside the block can fetch that line safely.

A miss to a line address that is already being tracked joins the existing entry and does not take a new slot. Request IDs must be unique among outstanding entries, and the joined entry keeps the ID of the miss that allocated it. The forwarding, install and safe-address outputs are combinational on the same cycle as the event that causes them.

Top module: `nofill_miss_table`

## Requirements
- R1: After reset no entry is valid: `full` is low, `miss_ready` is high, and `fwd_valid`, `fill_en` and `safe_valid` are low.
- R2: An accepted miss whose line address matches no valid entry allocates a new entry holding that address, that ID and that suppress flag (`miss_nofill`=1 means suppress).
- R3: A response whose `rsp_id` matches a valid entry raises `fwd_valid` in the same cycle, with `fwd_id`=`rsp_id` and `fwd_data`=`rsp_data`. The entry is freed at the following clock edge.
- R4: A response for an entry whose suppress flag is still set gives no `fill_en`.
- R5: A response for an entry whose flag is clear raises `fill_en` for exactly that cycle, with `fill_addr` set to the entry's line address and `fill_data`=`rsp_data`.
- R6: An authorization naming a valid entry clears its flag. An authorization in the same cycle as that entry's response also counts, so the line is installed.
- R7: An authorization naming the ID of a suppressed response that has already completed raises `safe_valid` for one cycle with that line address, and never raises `fill_en`. A second authorization for the same ID gives nothing.
- R8: A miss to a line address held by a valid entry that is not being answered in that cycle merges into that entry. The entry's flag becomes the AND of the two flags, and no new slot is used.
- R9: With all 8 entries valid, `full` is high and `miss_ready` is low unless the miss merges.
- R10: A response or authorization whose ID matches no valid entry and no completed suppressed line changes no output and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | ADDR_W | Line address of the miss |
| miss_id | input | ID_W | Request ID of the miss |
| miss_nofill | input | 1 | 1 = access not yet safe, suppress install |
| miss_ready | output | 1 | Miss is accepted this cycle |
| full | output | 1 | All entries valid |
| auth_valid | input | 1 | Authorization event present |
| auth_id | input | ID_W | Request ID being authorized |
| rsp_valid | input | 1 | Memory response present |
| rsp_id | input | ID_W | Request ID of the response |
| rsp_data | input | DATA_W | Returned line data |
| fwd_valid | output | 1 | Data forwarded to requester |
| fwd_id | output | ID_W | ID of forwarded data |
| fwd_data | output | DATA_W | Forwarded data |
| fill_en | output | 1 | One-cycle install pulse to the cache array |
| fill_addr | output | ADDR_W | Line address to install |
| fill_data | output | DATA_W | Line data to install |
| safe_valid | output | 1 | Late authorization of a suppressed line |
| safe_addr | output | ADDR_W | Line address now deemed safe |

## Verification
Almost every fault in the table shows up at the ports on the cycle the affected entry is next touched. A lost or stale suppress flag flips `fill_en` on the response cycle. A wrongly freed or leaked slot changes `full` and `miss_ready` within a few allocations. A dropped record of a completed suppressed line silences `safe_valid` on the next authorization. The bench therefore drives each ordering of authorization against response, including the same cycle, as well as merges with mixed flags and a full table. It compares every output against a behavioural model on every cycle, so a divergence is reported on the first cycle it becomes visible.

// File: rtl/nofill_miss_table.sv
module nofill_miss_table #(
  parameter int ADDR_W  = 32,
  parameter int ID_W    = 4,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [ID_W-1:0]   miss_id,
  input  logic              miss_nofill,
  output logic              miss_ready,
  output logic              full,
  input  logic              auth_valid,
  input  logic [ID_W-1:0]   auth_id,
  input  logic              rsp_valid,
  input  logic [ID_W-1:0]   rsp_id,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              fwd_valid,
  output logic [ID_W-1:0]   fwd_id,
  output logic [DATA_W-1:0] fwd_data,
  output logic              fill_en,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data,
  output logic              safe_valid,
  output logic [ADDR_W-1:0] safe_addr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int NIDS  = 1 << ID_W;

  logic [ENTRIES-1:0] vld, nf;
  logic [ADDR_W-1:0]  ent_addr [ENTRIES];
  logic [ID_W-1:0]    ent_id   [ENTRIES];
  logic [NIDS-1:0]    done_v;
  logic [ADDR_W-1:0]  done_addr [NIDS];

  logic [ENTRIES-1:0] rsp_hit, auth_hit, mrg;
  logic [IDX_W-1:0]   free_ix, rsp_ix;
  logic               merge_hit, alloc;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      rsp_hit[i]  = rsp_valid  && vld[i] && ent_id[i] == rsp_id;
      auth_hit[i] = auth_valid && vld[i] && ent_id[i] == auth_id;
      mrg[i]      = miss_valid && vld[i] && !rsp_hit[i] && ent_addr[i] == miss_addr;
    end
  end

  always_comb begin
    free_ix = '0;
    rsp_ix  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i])    free_ix = IDX_W'(i);
      if (rsp_hit[i]) rsp_ix  = IDX_W'(i);
    end
  end

  assign merge_hit  = |mrg;
  assign full       = &vld;
  assign miss_ready = merge_hit || !full;
  assign alloc      = miss_valid && !merge_hit && !full;

  assign fwd_valid  = |rsp_hit;
  assign fwd_id     = rsp_id;
  assign fwd_data   = rsp_data;
  assign fill_en    = fwd_valid && !(nf[rsp_ix] && !auth_hit[rsp_ix]);
  assign fill_addr  = ent_addr[rsp_ix];
  assign fill_data  = rsp_data;
  assign safe_valid = auth_valid && !(|auth_hit) && done_v[auth_id];
  assign safe_addr  = done_addr[auth_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      nf     <= '0;
      done_v <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_addr[i] <= '0;
        ent_id[i]   <= '0;
      end
      for (int k = 0; k < NIDS; k++) done_addr[k] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (rsp_hit[i]) vld[i] <= 1'b0;
        else nf[i] <= nf[i] & ~auth_hit[i] & (mrg[i] ? miss_nofill : 1'b1);
      end
      if (alloc) begin
        vld[free_ix]      <= 1'b1;
        nf[free_ix]       <= miss_nofill;
        ent_addr[free_ix] <= miss_addr;
        ent_id[free_ix]   <= miss_id;
      end
      if (fwd_valid && !fill_en) begin
        done_v[rsp_id]    <= 1'b1;
        done_addr[rsp_id] <= ent_addr[rsp_ix];
      end
      if (safe_valid) done_v[auth_id] <= 1'b0;
      if (alloc) done_v[miss_id] <= 1'b0;
    end
  end

  p_fill_needs_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> fwd_valid && fill_data == rsp_data);
  p_one_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> !(fill_en && rsp_id == $past(rsp_id)));
  p_fwd_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && |rsp_hit) |-> fwd_valid && fwd_data == rsp_data);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready && full) |-> merge_hit);
  p_safe_not_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    safe_valid |-> !(|auth_hit));
  p_onehot_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_hit));
endmodule

// File: tb/nofill_miss_table_tb_top.sv
module nofill_miss_table_tb_top;
  localparam int AW = 32, IW = 4, DW = 32, NE = 8, NI = 16;

  logic clk = 0, rst_n = 0;
  logic miss_valid = 0, miss_nofill = 0, auth_valid = 0, rsp_valid = 0;
  logic [AW-1:0] miss_addr = '0;
  logic [IW-1:0] miss_id = '0, auth_id = '0, rsp_id = '0;
  logic [DW-1:0] rsp_data = '0;
  logic miss_ready, full, fwd_valid, fill_en, safe_valid;
  logic [IW-1:0] fwd_id;
  logic [DW-1:0] fwd_data, fill_data;
  logic [AW-1:0] fill_addr, safe_addr;

  int total = 0, bad = 0;
  bit m_v [NI], m_nf [NI], m_r [NI];
  logic [AW-1:0] m_a [NI], m_ra [NI];

  always #5 clk = ~clk;

  nofill_miss_table #(.ADDR_W(AW), .ID_W(IW), .DATA_W(DW), .ENTRIES(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_id(miss_id), .miss_nofill(miss_nofill), .miss_ready(miss_ready), .full(full),
    .auth_valid(auth_valid), .auth_id(auth_id), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_data(rsp_data), .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_data(fwd_data),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
    .safe_valid(safe_valid), .safe_addr(safe_addr));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    int cnt = 0, mk = -1;
    bit ehit, eauth, efill, esafe, eready, efull;
    #1;
    for (int k = 0; k < NI; k++) begin
      cnt += int'(m_v[k]);
      if (miss_valid && m_v[k] && m_a[k] == miss_addr && !(rsp_valid && rsp_id == IW'(k))) mk = k;
    end
    efull  = cnt == NE;
    eready = mk >= 0 || !efull;
    ehit   = rsp_valid && m_v[rsp_id];
    eauth  = auth_valid && m_v[auth_id];
    efill  = ehit && !(m_nf[rsp_id] && !(eauth && auth_id == rsp_id));
    esafe  = auth_valid && !eauth && m_r[auth_id];
    chk(full == efull, "R9 full", 64'(full), 64'(efull));
    chk(miss_ready == eready, "R9 miss_ready", 64'(miss_ready), 64'(eready));
    chk(fwd_valid == ehit, "R3 fwd_valid", 64'(fwd_valid), 64'(ehit));
    if (ehit) chk(fwd_id == rsp_id && fwd_data == rsp_data, "R3 fwd payload", 64'(fwd_data), 64'(rsp_data));
    chk(fill_en == efill, "R4/R5/R6 fill_en", 64'(fill_en), 64'(efill));
    if (efill) chk(fill_addr == m_a[rsp_id] && fill_data == rsp_data, "R5 fill payload", 64'(fill_addr), 64'(m_a[rsp_id]));
    chk(safe_valid == esafe, "R7 safe_valid", 64'(safe_valid), 64'(esafe));
    if (esafe) chk(safe_addr == m_ra[auth_id], "R7 safe_addr", 64'(safe_addr), 64'(m_ra[auth_id]));
    @(posedge clk);
    for (int k = 0; k < NI; k++) if (eauth && auth_id == IW'(k) && !(ehit && rsp_id == IW'(k))) m_nf[k] = 0;
    if (mk >= 0) m_nf[mk] = m_nf[mk] & miss_nofill & !(eauth && auth_id == IW'(mk));
    if (ehit) begin
      m_v[rsp_id] = 0;
      if (!efill) begin m_r[rsp_id] = 1; m_ra[rsp_id] = m_a[rsp_id]; end
    end
    if (esafe) m_r[auth_id] = 0;
    if (miss_valid && mk < 0 && !efull) begin
      m_v[miss_id] = 1; m_nf[miss_id] = miss_nofill; m_a[miss_id] = miss_addr; m_r[miss_id] = 0;
    end
    @(negedge clk);
    miss_valid = 0; auth_valid = 0; rsp_valid = 0;
  endtask

  task automatic set_miss(input logic [AW-1:0] a, input int id, input bit n);
    miss_valid = 1; miss_addr = a; miss_id = IW'(id); miss_nofill = n;
  endtask
  task automatic set_auth(input int id);
    auth_valid = 1; auth_id = IW'(id);
  endtask
  task automatic set_rsp(input int id, input logic [DW-1:0] d);
    rsp_valid = 1; rsp_id = IW'(id); rsp_data = d;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();                                              // R1 reset state
    set_miss(32'h100, 1, 0); step();                     // R2 allocate safe miss
    set_rsp(1, 32'hA1); step();                          // R5 fill on return
    set_miss(32'h200, 2, 1); step();
    set_rsp(2, 32'hA2); step();                          // R4 suppressed
    set_auth(2); step();                                 // R7 late auth -> safe
    set_auth(2); step();                                 // R7 second auth ignored
    set_miss(32'h300, 3, 1); step();
    set_auth(3); step();                                 // R6 early auth
    set_rsp(3, 32'hA3); step();
    set_miss(32'h400, 4, 1); step();
    set_auth(4); set_rsp(4, 32'hA4); step();             // R6 same-cycle auth
    set_miss(32'h500, 5, 1); step();
    set_miss(32'h500, 6, 0); step();                     // R8 merge AND -> clear
    set_rsp(5, 32'hA5); step();
    set_rsp(6, 32'hA6); step();                          // R10 unknown id
    set_miss(32'h600, 7, 1); step();
    set_miss(32'h600, 8, 1); step();                     // R8 merge stays set
    set_rsp(7, 32'hA7); step();
    set_auth(9); step();                                 // R10 unknown auth
    for (int k = 0; k < NE; k++) begin set_miss(32'h1000 + 32'(k * 64), k, k % 2); step(); end
    set_miss(32'h9000, 9, 0); step();                    // R9 refused when full
    set_miss(32'h1040, 10, 0); step();                   // R9/R8 merge while full
    set_miss(32'h1080, 11, 0); set_rsp(2, 32'hB2); step(); // R8 no merge into answered entry
    set_miss(32'h1080, 12, 0); step();                   // R9 allocate after free
    for (int k = 0; k < NE; k++) begin
      if (k != 2) begin set_rsp(k, 32'hC0 + 32'(k)); step(); end
    end
    set_rsp(12, 32'hCC); step();
    set_auth(3); step();                                 // R7 safe for suppressed id 3
    set_auth(2); step();                                 // R7 id 2 suppressed before
    step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule